// File: doc/BRIEF.md
# Bus Monitor Terminal Filter and Recorder

This block sits behind a MIL-STD-1553 word decoder and decides, message by message, whether the traffic is worth keeping. A message is kept when the monitor is switched on and the remote-terminal address in its command word is wanted. The host can select every terminal, or only the terminals whose bits it has set in a 32-bit mask. Each kept message goes into a record block in a shared, word-addressed RAM. The host builds these blocks beforehand and chains them into a list through a next-block pointer word.

The block reads two pointers from the current record: where its data words go, and where the next record starts. Data words are stored as they arrive. When the message ends, the block fills in the record's header words and moves on along the chain. A free-running microsecond strobe feeds a time tag kept in each record. Every n-th stored record can raise a one-cycle interrupt pulse.

The sequencer has these states. IDLE waits for the enable. RD_DPTR and RD_TAIL issue the two pointer reads. LATCH_TAIL takes the second read. READY waits for a message. DATA stores data words until the end strobe. WR_CTRL, WR_CMD1, WR_CMD2, WR_STAT1 and WR_STAT2 write the header words. NEXT adopts the next-block pointer.

The transitions are:
- IDLE goes to RD_DPTR when enabled.
- RD_DPTR goes to RD_TAIL, RD_TAIL goes to LATCH_TAIL, and LATCH_TAIL goes to READY.
- READY goes to DATA when a message is accepted. It goes to IDLE when the enable is cleared.
- DATA goes to WR_CTRL on the end strobe.
- The header states run in sequence from WR_CTRL through WR_STAT2, then to NEXT.
- NEXT goes to RD_DPTR, or to IDLE if the enable is now clear.
- A load of the first-record pointer forces IDLE from any state.

Top module: `bm_recorder`

## Requirements
- R1: With control bit 15 (enable) clear, an arriving message causes no RAM write. After reset, enable is clear and `ram_we`, `ram_re` and `irq` are low.
- R2: With bit 13 set and bit 14 clear, a message is stored exactly when the mask bit for command-word-one address bits 15:11 is set. Register 1 bits 0..15 cover addresses 0..15 and register 2 bits 0..15 cover addresses 16..31.
- R3: With bit 14 set, every address is stored and the mask is ignored. With both bits 13 and 14 clear, nothing is stored.
- R4: For a terminal-to-terminal message (`msg_rtrt`=1), a selected address in either command word is enough. Such a record keeps command word two and status word two. For other messages those two slots are written as zero, and command word two's address does not select.
- R5: Any host write to register 3 (reset command) clears the enable bit, after which messages are dropped.
- R6: Relative to the record start, the block writes offset 1 (control), 2 (command one), 3 (command two), 5 (status one) and 6 (status two). It never writes offsets 0, 4 and 7.
- R7: The stored control word has bit 12 = 1 for bus A, bit 14 = message error, and bits 7:0 = (time strobes before the message start / TAG_DIV) mod 256. All other bits are zero.
- R8: Data words are written in arrival order to the address in offset 4 plus 0, 1, 2 and so on. At most 32 are stored and later ones are dropped.
- R9: Register 4 sets the first record's address. After each record, the next record goes to the address held in offset 7 of the one just finished.
- R10: `irq` pulses for one cycle after every n-th stored record, where n is control bits 7:0. An n of 0 gives no pulses.
- R11: `ram_we` and `ram_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_sel | input | 3 | Register: 0 control, 1 mask low, 2 mask high, 3 reset command, 4 first record |
| reg_wdata | input | 16 | Host write data |
| tick_us | input | 1 | Time-base strobe, one per microsecond |
| msg_start | input | 1 | Start of a decoded message, command words valid |
| msg_rtrt | input | 1 | Message is terminal-to-terminal |
| msg_cmd1 | input | 16 | Command word one |
| msg_cmd2 | input | 16 | Command word two |
| data_valid | input | 1 | Data word strobe |
| data_word | input | 16 | Data word |
| msg_end | input | 1 | End of message, status and flags valid |
| msg_stat1 | input | 16 | Status word one |
| msg_stat2 | input | 16 | Status word two |
| msg_bus_a | input | 1 | Message came on bus A |
| msg_err | input | 1 | Message had an error |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe, data returned next cycle |
| ram_addr | output | AW | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data |
| irq | output | 1 | Interrupt pulse |

## Verification
Every one of the 32 terminal addresses is sent under an irregular selection mask and again under all-terminals mode. This tells a correct index-to-mask mapping apart from a shifted or half-swapped one, and shows that the mask really is ignored in all-terminals mode. Data counts vary per message from none up to more than 32, so the cap and the data addressing are both tested. Varying tick counts separate the time tag from a raw count. Alternating bus and error flags expose swapped control bits. Terminal-to-terminal messages are sent with a match in only the second command word, once with the terminal-to-terminal flag set and once with it clear, to show which word is allowed to select.

// File: rtl/bm_pkg.sv
package bm_pkg;
    localparam int WORD_W = 16;

    // host register codes
    localparam logic [2:0] REG_CTRL   = 3'd0;
    localparam logic [2:0] REG_MASKLO = 3'd1;
    localparam logic [2:0] REG_MASKHI = 3'd2;
    localparam logic [2:0] REG_RSTCMD = 3'd3;
    localparam logic [2:0] REG_FIRST  = 3'd4;

    // control register bits
    localparam int CTL_EN  = 15;
    localparam int CTL_ALL = 14;
    localparam int CTL_SEL = 13;

    // record slot offsets
    localparam int OFF_CTRL  = 1;
    localparam int OFF_CMD1  = 2;
    localparam int OFF_CMD2  = 3;
    localparam int OFF_DPTR  = 4;
    localparam int OFF_STAT1 = 5;
    localparam int OFF_STAT2 = 6;
    localparam int OFF_TAIL  = 7;

    // stored control word bits
    localparam int REC_ERR = 14;
    localparam int REC_BUS = 12;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_DPTR, S_RD_TAIL, S_LATCH_TAIL, S_READY, S_DATA,
        S_WR_CTRL, S_WR_CMD1, S_WR_CMD2, S_WR_STAT1, S_WR_STAT2, S_NEXT
    } rec_state_e;
endpackage

// File: rtl/bm_regs.sv
module bm_regs
    import bm_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic              en,
    output logic              mode_all,
    output logic              mode_sel,
    output logic [7:0]        irq_every,
    output logic [31:0]       sel_mask,
    output logic              ptr_load,
    output logic [AW-1:0]     ptr_val
);
    logic [15:0] mask_lo, mask_hi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en        <= 1'b0;
            mode_all  <= 1'b0;
            mode_sel  <= 1'b0;
            irq_every <= '0;
            mask_lo   <= '0;
            mask_hi   <= '0;
        end else if (reg_wr) begin
            unique case (reg_sel)
                REG_CTRL: begin
                    en        <= reg_wdata[CTL_EN];
                    mode_all  <= reg_wdata[CTL_ALL];
                    mode_sel  <= reg_wdata[CTL_SEL];
                    irq_every <= reg_wdata[7:0];
                end
                REG_MASKLO: mask_lo <= reg_wdata;
                REG_MASKHI: mask_hi <= reg_wdata;
                REG_RSTCMD: en      <= 1'b0;
                default: ;
            endcase
        end
    end

    assign sel_mask = {mask_hi, mask_lo};
    assign ptr_load = reg_wr && (reg_sel == REG_FIRST);
    assign ptr_val  = AW'(reg_wdata);
endmodule

// File: rtl/bm_timebase.sv
module bm_timebase #(
    parameter int TAG_DIV = 64,
    parameter int TAG_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [TAG_W-1:0] tag
);
    localparam int PW = (TAG_DIV > 1) ? $clog2(TAG_DIV) : 1;
    logic [PW-1:0] pre;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre <= '0;
            tag <= '0;
        end else if (tick) begin
            if (pre == PW'(TAG_DIV - 1)) begin
                pre <= '0;
                tag <= tag + 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bm_filter.sv
module bm_filter (
    input  logic        mode_all,
    input  logic        mode_sel,
    input  logic [31:0] sel_mask,
    input  logic [4:0]  addr1,
    input  logic [4:0]  addr2,
    input  logic        rtrt,
    output logic        match
);
    always_comb begin
        if (mode_all)
            match = 1'b1;
        else if (mode_sel)
            match = sel_mask[addr1] | (rtrt & sel_mask[addr2]);
        else
            match = 1'b0;
    end
endmodule

// File: rtl/bm_fsm.sv
module bm_fsm
    import bm_pkg::*;
#(
    parameter int AW   = 16,
    parameter int MAXW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              match,
    input  logic              ptr_load,
    input  logic [AW-1:0]     ptr_val,
    input  logic [7:0]        irq_every,
    input  logic [7:0]        tag,
    input  logic              msg_start,
    input  logic              msg_rtrt,
    input  logic [WORD_W-1:0] msg_cmd1,
    input  logic [WORD_W-1:0] msg_cmd2,
    input  logic              data_valid,
    input  logic [WORD_W-1:0] data_word,
    input  logic              msg_end,
    input  logic [WORD_W-1:0] msg_stat1,
    input  logic [WORD_W-1:0] msg_stat2,
    input  logic              msg_bus_a,
    input  logic              msg_err,
    input  logic [WORD_W-1:0] ram_rdata,
    output logic              ram_we,
    output logic              ram_re,
    output logic [AW-1:0]     ram_addr,
    output logic [WORD_W-1:0] ram_wdata,
    output logic              irq,
    output rec_state_e        state_o,
    output logic [AW-1:0]     cur_o,
    output logic [AW-1:0]     tail_o,
    output logic [AW-1:0]     dptr_o
);
    localparam int IW = $clog2(MAXW + 1);

    rec_state_e          state, nxt;
    logic [AW-1:0]       cur, tail, dptr;
    logic [IW-1:0]       idx;
    logic [WORD_W-1:0]   cmd1_q, cmd2_q, stat1_q, stat2_q;
    logic                rtrt_q, bus_q, err_q;
    logic [7:0]          tag_q, rec_cnt;
    logic                accept, room, irq_hit;
    logic [WORD_W-1:0]   ctrl_word;

    assign accept  = msg_start && en && match;
    assign room    = idx < IW'(MAXW);
    assign irq_hit = (irq_every != 8'd0) && ((rec_cnt + 8'd1) >= irq_every);

    always_comb begin
        ctrl_word          = '0;
        ctrl_word[REC_ERR] = err_q;
        ctrl_word[REC_BUS] = bus_q;
        ctrl_word[7:0]     = tag_q;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next-state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:       if (en) nxt = S_RD_DPTR;
            S_RD_DPTR:    nxt = S_RD_TAIL;
            S_RD_TAIL:    nxt = S_LATCH_TAIL;
            S_LATCH_TAIL: nxt = S_READY;
            S_READY: begin
                if (!en)         nxt = S_IDLE;
                else if (accept) nxt = S_DATA;
            end
            S_DATA:       if (msg_end) nxt = S_WR_CTRL;
            S_WR_CTRL:    nxt = S_WR_CMD1;
            S_WR_CMD1:    nxt = S_WR_CMD2;
            S_WR_CMD2:    nxt = S_WR_STAT1;
            S_WR_STAT1:   nxt = S_WR_STAT2;
            S_WR_STAT2:   nxt = S_NEXT;
            S_NEXT:       nxt = en ? S_RD_DPTR : S_IDLE;
            default:      nxt = S_IDLE;
        endcase
        if (ptr_load) nxt = S_IDLE;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur     <= '0;
            tail    <= '0;
            dptr    <= '0;
            idx     <= '0;
            cmd1_q  <= '0;
            cmd2_q  <= '0;
            stat1_q <= '0;
            stat2_q <= '0;
            rtrt_q  <= 1'b0;
            bus_q   <= 1'b0;
            err_q   <= 1'b0;
            tag_q   <= '0;
            rec_cnt <= '0;
        end else begin
            unique case (state)
                S_RD_TAIL:    dptr <= ram_rdata[AW-1:0];
                S_LATCH_TAIL: tail <= ram_rdata[AW-1:0];
                S_READY: if (accept) begin
                    cmd1_q <= msg_cmd1;
                    cmd2_q <= msg_cmd2;
                    rtrt_q <= msg_rtrt;
                    tag_q  <= tag;
                    idx    <= '0;
                end
                S_DATA: begin
                    if (data_valid && room) idx <= idx + 1'b1;
                    if (msg_end) begin
                        stat1_q <= msg_stat1;
                        stat2_q <= msg_stat2;
                        bus_q   <= msg_bus_a;
                        err_q   <= msg_err;
                    end
                end
                S_NEXT: begin
                    cur     <= tail;
                    rec_cnt <= irq_hit ? 8'd0 : rec_cnt + 8'd1;
                end
                default: ;
            endcase
            if (ptr_load) cur <= ptr_val;
        end
    end

    // outputs
    always_comb begin
        ram_we    = 1'b0;
        ram_re    = 1'b0;
        ram_addr  = cur;
        ram_wdata = '0;
        irq       = 1'b0;
        unique case (state)
            S_RD_DPTR: begin ram_re = 1'b1; ram_addr = cur + AW'(OFF_DPTR); end
            S_RD_TAIL: begin ram_re = 1'b1; ram_addr = cur + AW'(OFF_TAIL); end
            S_DATA: begin
                ram_we    = data_valid && room;
                ram_addr  = dptr + AW'(idx);
                ram_wdata = data_word;
            end
            S_WR_CTRL:  begin ram_we = 1'b1; ram_addr = cur + AW'(OFF_CTRL);  ram_wdata = ctrl_word; end
            S_WR_CMD1:  begin ram_we = 1'b1; ram_addr = cur + AW'(OFF_CMD1);  ram_wdata = cmd1_q; end
            S_WR_CMD2:  begin ram_we = 1'b1; ram_addr = cur + AW'(OFF_CMD2);  ram_wdata = rtrt_q ? cmd2_q : '0; end
            S_WR_STAT1: begin ram_we = 1'b1; ram_addr = cur + AW'(OFF_STAT1); ram_wdata = stat1_q; end
            S_WR_STAT2: begin ram_we = 1'b1; ram_addr = cur + AW'(OFF_STAT2); ram_wdata = rtrt_q ? stat2_q : '0; end
            S_NEXT:     irq = irq_hit;
            default: ;
        endcase
    end

    assign state_o = state;
    assign cur_o   = cur;
    assign tail_o  = tail;
    assign dptr_o  = dptr;
endmodule

// File: rtl/bm_recorder.sv
module bm_recorder
    import bm_pkg::*;
#(
    parameter int AW      = 16,
    parameter int MAXW    = 32,
    parameter int TAG_DIV = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_sel,
    input  logic [15:0]   reg_wdata,
    input  logic          tick_us,
    input  logic          msg_start,
    input  logic          msg_rtrt,
    input  logic [15:0]   msg_cmd1,
    input  logic [15:0]   msg_cmd2,
    input  logic          data_valid,
    input  logic [15:0]   data_word,
    input  logic          msg_end,
    input  logic [15:0]   msg_stat1,
    input  logic [15:0]   msg_stat2,
    input  logic          msg_bus_a,
    input  logic          msg_err,
    output logic          ram_we,
    output logic          ram_re,
    output logic [AW-1:0] ram_addr,
    output logic [15:0]   ram_wdata,
    input  logic [15:0]   ram_rdata,
    output logic          irq
);
    logic          en, mode_all, mode_sel, ptr_load, match;
    logic [7:0]    irq_every, tag;
    logic [31:0]   sel_mask;
    logic [AW-1:0] ptr_val, cur_ptr, tail_ptr, dptr;
    rec_state_e    fsm_state;

    bm_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .en(en), .mode_all(mode_all), .mode_sel(mode_sel),
        .irq_every(irq_every), .sel_mask(sel_mask), .ptr_load(ptr_load),
        .ptr_val(ptr_val)
    );

    bm_timebase #(.TAG_DIV(TAG_DIV), .TAG_W(8)) u_time (
        .clk(clk), .rst_n(rst_n), .tick(tick_us), .tag(tag)
    );

    bm_filter u_filt (
        .mode_all(mode_all), .mode_sel(mode_sel), .sel_mask(sel_mask),
        .addr1(msg_cmd1[15:11]), .addr2(msg_cmd2[15:11]), .rtrt(msg_rtrt),
        .match(match)
    );

    bm_fsm #(.AW(AW), .MAXW(MAXW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .match(match), .ptr_load(ptr_load),
        .ptr_val(ptr_val), .irq_every(irq_every), .tag(tag),
        .msg_start(msg_start), .msg_rtrt(msg_rtrt), .msg_cmd1(msg_cmd1),
        .msg_cmd2(msg_cmd2), .data_valid(data_valid), .data_word(data_word),
        .msg_end(msg_end), .msg_stat1(msg_stat1), .msg_stat2(msg_stat2),
        .msg_bus_a(msg_bus_a), .msg_err(msg_err), .ram_rdata(ram_rdata),
        .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .irq(irq), .state_o(fsm_state),
        .cur_o(cur_ptr), .tail_o(tail_ptr), .dptr_o(dptr)
    );
endmodule

// File: rtl/bm_checker.sv
module bm_checker
    import bm_pkg::*;
#(
    parameter int AW   = 16,
    parameter int MAXW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ram_we,
    input logic          ram_re,
    input logic [AW-1:0] ram_addr,
    input logic          irq,
    input logic          reg_wr,
    input logic [2:0]    reg_sel,
    input logic          en,
    input logic          ptr_load,
    input rec_state_e    state,
    input logic [AW-1:0] cur_ptr,
    input logic [AW-1:0] tail_ptr,
    input logic [AW-1:0] dptr
);
    logic [AW-1:0] data_off;
    assign data_off = ram_addr - dptr;

    AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re)); // R11

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R10

    AST_RSTCMD_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == REG_RSTCMD) |=> !en); // R5

    AST_DATA_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && ram_we) |-> (data_off < AW'(MAXW))); // R8

    AST_FOLLOW_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_NEXT && !ptr_load) |=> (cur_ptr == $past(tail_ptr))); // R9

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READY && !en) |=> !ram_we); // R1
endmodule

bind bm_recorder bm_checker #(.AW(AW), .MAXW(MAXW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .ram_re(ram_re),
    .ram_addr(ram_addr), .irq(irq), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .en(en), .ptr_load(ptr_load), .state(fsm_state), .cur_ptr(cur_ptr),
    .tail_ptr(tail_ptr), .dptr(dptr)
);

// File: tb/tb_bm_recorder.sv
`timescale 1ns/1ps
module tb_bm_recorder;
    localparam int AW = 16, MAXW = 32, TAG_DIV = 4;
    localparam logic [31:0] MASK = 32'h9C3A_5E61;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 0; logic [2:0] reg_sel = 0; logic [15:0] reg_wdata = 0;
    logic tick_us = 0, msg_start = 0, msg_rtrt = 0, data_valid = 0, msg_end = 0;
    logic msg_bus_a = 0, msg_err = 0;
    logic [15:0] msg_cmd1 = 0, msg_cmd2 = 0, data_word = 0, msg_stat1 = 0, msg_stat2 = 0;
    logic ram_we, ram_re, irq;
    logic [AW-1:0] ram_addr;
    logic [15:0] ram_wdata, ram_rdata;

    always #10 clk = ~clk;

    bm_recorder #(.AW(AW), .MAXW(MAXW), .TAG_DIV(TAG_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .tick_us(tick_us), .msg_start(msg_start),
        .msg_rtrt(msg_rtrt), .msg_cmd1(msg_cmd1), .msg_cmd2(msg_cmd2),
        .data_valid(data_valid), .data_word(data_word), .msg_end(msg_end),
        .msg_stat1(msg_stat1), .msg_stat2(msg_stat2), .msg_bus_a(msg_bus_a),
        .msg_err(msg_err), .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .irq(irq)
    );

    function automatic int blk_base(int k); return 16'h40 + 16 * k; endfunction
    function automatic int blk_data(int k); return 16'h200 + 64 * k; endfunction

    // RAM model with pre-built ring of four record blocks
    logic [15:0] mem [0:1023];
    int wr_cnt = 0, irq_cnt = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            ram_rdata <= '0;
            for (int k = 0; k < 4; k++) begin
                mem[blk_base(k) + 0] <= 16'(16'hA000 + k);
                mem[blk_base(k) + 4] <= 16'(blk_data(k));
                mem[blk_base(k) + 7] <= 16'(blk_base((k + 1) % 4));
                mem[blk_data(k) + 32] <= 16'hDEAD;
            end
        end else begin
            if (ram_we) begin mem[ram_addr[9:0]] <= ram_wdata; wr_cnt <= wr_cnt + 1; end
            if (ram_re) ram_rdata <= mem[ram_addr[9:0]];
            if (irq) irq_cnt <= irq_cnt + 1;
        end
    end

    int n_chk = 0, n_fail = 0;
    int exp_k = 0, tick_total = 0, cap_total = 0, irq_cfg = 3;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
        repeat (6) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_us = 1;
            @(negedge clk); tick_us = 0;
            tick_total++;
        end
    endtask

    function automatic logic [15:0] dword(logic [15:0] c, int i);
        return c ^ 16'(i * 16'h0101) ^ 16'h5A00;
    endfunction

    task automatic run_msg(input logic [15:0] c1, input logic [15:0] c2, input bit rt,
                           input int wc, input logic [15:0] s1, input logic [15:0] s2,
                           input bit ba, input bit er, input bit expect_cap, input string req);
        int w0, i0, nst, base, dp, bad;
        logic [15:0] ectl;
        w0 = wr_cnt; i0 = irq_cnt;
        @(negedge clk);
        msg_start = 1; msg_cmd1 = c1; msg_cmd2 = c2; msg_rtrt = rt;
        @(negedge clk); msg_start = 0;
        for (int i = 0; i < wc; i++) begin
            data_valid = 1; data_word = dword(c1, i);
            @(negedge clk);
        end
        data_valid = 0;
        msg_end = 1; msg_stat1 = s1; msg_stat2 = s2; msg_bus_a = ba; msg_err = er;
        @(negedge clk); msg_end = 0;
        repeat (14) @(negedge clk);
        nst = (wc > 32) ? 32 : wc;
        chk((wr_cnt - w0) == (expect_cap ? nst + 5 : 0), req, wr_cnt - w0, expect_cap ? nst + 5 : 0);
        if (expect_cap) begin
            cap_total++;
            base = blk_base(exp_k); dp = blk_data(exp_k);
            ectl = 16'((tick_total / TAG_DIV) % 256);
            ectl[12] = ba; ectl[14] = er;
            chk(mem[base + 1] == ectl, "R7 control word", mem[base + 1], ectl);
            chk(mem[base + 2] == c1, "R9 record placed at tail target", mem[base + 2], c1);
            chk(mem[base + 3] == (rt ? c2 : 16'h0), "R4 command two slot", mem[base + 3], rt ? c2 : 0);
            chk(mem[base + 5] == s1, "R6 status one slot", mem[base + 5], s1);
            chk(mem[base + 6] == (rt ? s2 : 16'h0), "R4 status two slot", mem[base + 6], rt ? s2 : 0);
            chk(mem[base + 0] == 16'(16'hA000 + exp_k) && mem[base + 4] == 16'(dp) &&
                mem[base + 7] == 16'(blk_base((exp_k + 1) % 4)), "R6 pointer slots untouched",
                mem[base + 4], dp);
            bad = 0;
            for (int i = 0; i < nst; i++) if (mem[dp + i] != dword(c1, i)) bad++;
            chk(bad == 0, "R8 data words", bad, 0);
            chk(mem[dp + 32] == 16'hDEAD, "R8 cap at 32 words", mem[dp + 32], 16'hDEAD);
            exp_k = (exp_k + 1) % 4;
        end
        chk((irq_cnt - i0) == ((expect_cap && irq_cfg != 0 && cap_total % irq_cfg == 0) ? 1 : 0),
            "R10 interrupt", irq_cnt - i0,
            (expect_cap && irq_cfg != 0 && cap_total % irq_cfg == 0) ? 1 : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!ram_we && !ram_re && !irq, "R1 reset outputs", {ram_we, ram_re, irq}, 0);

        // R2 selective sweep
        host_wr(3'd4, 16'h0040);
        host_wr(3'd1, MASK[15:0]);
        host_wr(3'd2, MASK[31:16]);
        host_wr(3'd0, 16'hA003);
        for (int a = 0; a < 32; a++) begin
            ticks(a % 5);
            run_msg({5'(a), 11'(a * 37)}, 16'h0, 0, (a * 13) % 35, 16'(a * 16'h0811), 16'hFFFF,
                    a[0], a[1], MASK[a], "R2 select mask");
        end

        // R3 all terminals, mask ignored
        host_wr(3'd0, 16'hC003);
        for (int a = 0; a < 32; a++) begin
            ticks(3);
            run_msg({5'(a), 11'(a * 91)}, 16'h0, 0, a % 4, 16'(a), 16'h0, ~a[0], a[2], 1, "R3 all mode");
        end

        // R3 neither mode bit
        host_wr(3'd0, 16'h8003);
        run_msg({5'd0, 11'h12}, 16'h0, 0, 2, 16'h1, 16'h0, 1, 0, 0, "R3 no mode");

        // R4 terminal-to-terminal
        host_wr(3'd0, 16'hA003);
        run_msg({5'd1, 11'h421}, {5'd0, 11'h401}, 1, 3, 16'h0800, 16'h0001, 1, 0, 1, "R4 second address selects");
        run_msg({5'd1, 11'h421}, {5'd0, 11'h401}, 0, 3, 16'h0800, 16'h0001, 1, 0, 0, "R4 second ignored when not rtrt");
        run_msg({5'd1, 11'h421}, {5'd1, 11'h401}, 1, 3, 16'h0800, 16'h0001, 1, 0, 0, "R4 neither address selected");

        // R8 more than 32 words
        ticks(2);
        run_msg({5'd0, 11'h7FF}, 16'h0, 0, 34, 16'hBEEF, 16'h0, 0, 1, 1, "R8 overflow message");

        // R5 reset command, R1 enable clear
        host_wr(3'd3, 16'h0000);
        run_msg({5'd0, 11'h1}, 16'h0, 0, 2, 16'h0, 16'h0, 1, 0, 0, "R5 reset command drops");
        host_wr(3'd0, 16'h2003);
        run_msg({5'd0, 11'h1}, 16'h0, 0, 2, 16'h0, 16'h0, 1, 0, 0, "R1 disabled drops");
        host_wr(3'd0, 16'hA003);
        run_msg({5'd5, 11'h2}, 16'h0, 0, 1, 16'h55, 16'h0, 0, 0, 1, "R9 resume after re-enable");

        // R10 interval zero
        host_wr(3'd0, 16'hA000);
        irq_cfg = 0;
        for (int i = 0; i < 4; i++)
            run_msg({5'd6, 11'(i)}, 16'h0, 0, i, 16'(i), 16'h0, 1, 1, 1, "R10 interval zero");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule